// File: doc/BRIEF.md
# Row-Write Element-Read Two-Dimensional Memory

This block stores a grid of H by V entries, each B bits wide. Internally the grid is kept as V rows, each row packing all H entries side by side, so entry (h, v) lives in bits [h*B +: B] of row v. A single write port replaces a whole row (all H entries at once) in one cycle. There are no per-entry write enables. Each of the independent read ports takes an element coordinate (h, v), fetches row v from storage and then picks entry h with a selection multiplexer. A parameter may place a register after that multiplexer.

The row width is split into NUM_COLS column sub-memories that share the row address and write enable. This partitioning cannot be seen from the ports. V must be a power of two, so the row address is exactly log2(V) bits wide. H may be any positive integer. With H = 1 the block is a plain one-dimensional memory and the h input is ignored. The total read latency, 1 + MUX_REG cycles, is published as the localparam READ_LATENCY.

Each read port is a valid-only stream. A request is presented with rd_en and is always accepted. The response appears with rd_valid exactly READ_LATENCY cycles later. There is no ready signal and no back-pressure, so a consumer must take every response in the cycle it is offered.

Top module: `rwem_row_mem`

## Requirements
- R1: While and right after reset, every rd_valid bit is 0 and every rd_data lane is all zeros.
- R2: A cycle with wr_en = 1 replaces all H entries of row wr_row with wr_data. A later read of (h, v) returns bits [h*B +: B] of the last data written to row v.
- R3: A request accepted with rd_en high at one clock edge yields rd_valid high and its data exactly 1 + MUX_REG edges later. rd_valid is never raised earlier, and never raised without a request.
- R4: When H > 1, a request whose h is H or greater returns all zeros.
- R5: A read and a write to the same row at the same edge return the row contents from before the write (read-first). The next read returns the new contents.
- R6: The read ports are independent. Different coordinates on different ports in the same cycle each return their own entry, and identical coordinates return identical data.
- R7: A read data lane holds its value in every cycle where its rd_valid is low.
- R8: Presenting wr_row and wr_data with wr_en = 0 leaves the storage unchanged.
- R9: Splitting the row into column sub-memories is transparent. An entry whose bits straddle a column boundary (with default parameters entry 1 spans bits 8 to 15 across the boundary at bit 12) reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | log2(V) | Row written |
| wr_data | input | H*B | Full row contents, entry h at [h*B +: B] |
| rd_en | input | NUM_READ_PORTS | Read request per port |
| rd_row | input | NUM_READ_PORTS*log2(V) | Row index, port p at [p*log2(V) +: log2(V)] |
| rd_h | input | NUM_READ_PORTS*max(1,log2 H) | Entry index within the row, per port |
| rd_valid | output | NUM_READ_PORTS | Response strobe per port |
| rd_data | output | NUM_READ_PORTS*B | Selected entry per port |

## Verification
The bench builds the block with H = 3, V = 8, B = 8, two read ports, MUX_REG = 1 and two column sub-memories of 12 bits each. A non-power-of-two H means the 2-bit h input can carry the out-of-range value 3. The 12-bit column boundary falls inside entry 1, so a split that is mis-sliced shows up as a corrupted entry. The two-cycle latency lets the bench show that a response does not arrive one cycle early. With two ports, simultaneous requests that are equal and requests that differ can both be checked.

// File: rtl/rwem_pkg.sv
package rwem_pkg;
  // Width of an index over n items; never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of one column sub-memory when a row is cut into n parts.
  function automatic int part_w(input int total, input int n);
    return (total + n - 1) / n;
  endfunction
endpackage

// File: rtl/rwem_col_bank.sv
module rwem_col_bank #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int NRP   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic [NRP-1:0]       rd_en,
  input  logic [NRP*AW-1:0]    rd_addr,
  output logic [NRP*WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    logic [WIDTH-1:0] q_r;
    // Non-blocking read and write at one edge: the read sees the old row.
    always_ff @(posedge clk) begin
      if (rst)            q_r <= '0;
      else if (rd_en[p])  q_r <= store[rd_addr[p*AW +: AW]];
    end
    assign rd_q[p*WIDTH +: WIDTH] = q_r;
  end
endmodule

// File: rtl/rwem_entry_sel.sv
module rwem_entry_sel #(
  parameter int H       = 3,
  parameter int B       = 8,
  parameter int HW      = 2,
  parameter int MUX_REG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_en,
  input  logic [HW-1:0]  req_h,
  input  logic [H*B-1:0] row_in,
  output logic           out_valid,
  output logic [B-1:0]   out_data
);
  logic          stg1_v;
  logic [B-1:0]  picked;

  always_ff @(posedge clk) begin
    if (rst) stg1_v <= 1'b0;
    else     stg1_v <= req_en;
  end

  if (H > 1) begin : g_mux
    logic [HW-1:0] h_q;
    // The index travels with the row fetch so both belong to one request.
    always_ff @(posedge clk) begin
      if (rst)          h_q <= '0;
      else if (req_en)  h_q <= req_h;
    end
    always_comb begin
      picked = '0;
      for (int i = 0; i < H; i++) begin
        if (h_q == HW'(i)) picked = row_in[i*B +: B];
      end
    end
  end else begin : g_flat
    logic unused_h;
    assign unused_h = ^req_h;
    assign picked   = row_in;
  end

  if (MUX_REG != 0) begin : g_oreg
    logic         stg2_v;
    logic [B-1:0] data_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stg2_v <= 1'b0;
        data_q <= '0;
      end else begin
        stg2_v <= stg1_v;
        if (stg1_v) data_q <= picked;
      end
    end
    assign out_valid = stg2_v;
    assign out_data  = data_q;
  end else begin : g_comb
    assign out_valid = stg1_v;
    assign out_data  = picked;
  end
endmodule

// File: rtl/rwem_row_mem.sv
module rwem_row_mem #(
  parameter int H              = 3,
  parameter int V              = 8,
  parameter int B              = 8,
  parameter int NUM_READ_PORTS = 2,
  parameter int MUX_REG        = 1,
  parameter int NUM_COLS       = 2,
  localparam int AW            = $clog2(V),
  localparam int HW            = rwem_pkg::idx_w(H)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_row,
  input  logic [H*B-1:0]               wr_data,
  input  logic [NUM_READ_PORTS-1:0]    rd_en,
  input  logic [NUM_READ_PORTS*AW-1:0] rd_row,
  input  logic [NUM_READ_PORTS*HW-1:0] rd_h,
  output logic [NUM_READ_PORTS-1:0]    rd_valid,
  output logic [NUM_READ_PORTS*B-1:0]  rd_data
);
  localparam int ROW_W        = H * B;
  localparam int COL_W        = rwem_pkg::part_w(ROW_W, NUM_COLS);
  localparam int READ_LATENCY = 1 + MUX_REG;

  // Fetched rows for all ports, port p at [p*ROW_W +: ROW_W].
  logic [NUM_READ_PORTS*ROW_W-1:0] rows_q;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int LO  = c * COL_W;
    localparam int WID = (ROW_W - LO < COL_W) ? (ROW_W - LO) : COL_W;
    logic [NUM_READ_PORTS*WID-1:0] bank_q;

    rwem_col_bank #(
      .WIDTH (WID),
      .DEPTH (V),
      .AW    (AW),
      .NRP   (NUM_READ_PORTS)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_row),
      .wr_data (wr_data[LO +: WID]),
      .rd_en   (rd_en),
      .rd_addr (rd_row),
      .rd_q    (bank_q)
    );

    for (genvar p = 0; p < NUM_READ_PORTS; p++) begin : g_lane
      assign rows_q[p*ROW_W + LO +: WID] = bank_q[p*WID +: WID];
    end
  end

  for (genvar p = 0; p < NUM_READ_PORTS; p++) begin : g_port
    rwem_entry_sel #(
      .H       (H),
      .B       (B),
      .HW      (HW),
      .MUX_REG (MUX_REG)
    ) u_sel (
      .clk       (clk),
      .rst       (rst),
      .req_en    (rd_en[p]),
      .req_h     (rd_h[p*HW +: HW]),
      .row_in    (rows_q[p*ROW_W +: ROW_W]),
      .out_valid (rd_valid[p]),
      .out_data  (rd_data[p*B +: B])
    );
  end
endmodule

// File: rtl/rwem_row_mem_chk.sv
module rwem_row_mem_chk #(
  parameter int H              = 3,
  parameter int V              = 8,
  parameter int B              = 8,
  parameter int NUM_READ_PORTS = 2,
  parameter int MUX_REG        = 1,
  localparam int AW            = $clog2(V),
  localparam int HW            = rwem_pkg::idx_w(H),
  localparam int LAT           = 1 + MUX_REG
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_READ_PORTS-1:0]    rd_en,
  input logic [NUM_READ_PORTS*AW-1:0] rd_row,
  input logic [NUM_READ_PORTS*HW-1:0] rd_h,
  input logic [NUM_READ_PORTS-1:0]    rd_valid,
  input logic [NUM_READ_PORTS*B-1:0]  rd_data
);
  for (genvar p = 0; p < NUM_READ_PORTS; p++) begin : g_p
    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
      rd_valid[p] == $past(rd_en[p], LAT));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !rd_valid[p] |-> $stable(rd_data[p*B +: B]));

    if (H > 1) begin : g_rng
      assert_range_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid[p] && $past({1'b0, rd_h[p*HW +: HW]} >= (HW+1)'(H), LAT))
        |-> (rd_data[p*B +: B] == '0));
    end

    if (p > 0) begin : g_agree
      assert_ports_agree_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en[0] && rd_en[p]
              && rd_row[0 +: AW] == rd_row[p*AW +: AW]
              && rd_h[0 +: HW] == rd_h[p*HW +: HW], LAT)
        |-> (rd_data[0 +: B] == rd_data[p*B +: B]));
    end
  end
endmodule

bind rwem_row_mem rwem_row_mem_chk #(
  .H              (H),
  .V              (V),
  .B              (B),
  .NUM_READ_PORTS (NUM_READ_PORTS),
  .MUX_REG        (MUX_REG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_row   (rd_row),
  .rd_h     (rd_h),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/rwem_row_mem_bench.sv
module rwem_row_mem_bench;
  localparam int H = 3, V = 8, B = 8, NP = 2, MR = 1, NC = 2;
  localparam int AW = 3, HW = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_row = '0;
  logic [H*B-1:0]    wr_data = '0;
  logic [NP-1:0]     rd_en = '0;
  logic [NP*AW-1:0]  rd_row = '0;
  logic [NP*HW-1:0]  rd_h = '0;
  logic [NP-1:0]     rd_valid;
  logic [NP*B-1:0]   rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rwem_row_mem #(.H(H), .V(V), .B(B), .NUM_READ_PORTS(NP), .MUX_REG(MR),
                 .NUM_COLS(NC)) u_rwem_row_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_h(rd_h),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // Vector: {row[2:0], h[1:0], expected[7:0]}; entry (h,v) = v*16 + h + 1.
  localparam logic [12:0] VEC [8] = '{
    {3'd2, 2'd1, 8'h22}, {3'd7, 2'd2, 8'h73}, {3'd0, 2'd0, 8'h01},
    {3'd5, 2'd3, 8'h00}, {3'd3, 2'd0, 8'h31}, {3'd6, 2'd1, 8'h62},
    {3'd1, 2'd2, 8'h13}, {3'd4, 2'd1, 8'h42}};

  function automatic logic [H*B-1:0] row_pat(input int v);
    return {8'(v*16 + 3), 8'(v*16 + 2), 8'(v*16 + 1)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_row(input int v, input logic [H*B-1:0] d,
                           input logic en);
    @(negedge clk);
    wr_en = en; wr_row = AW'(v); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue a request; returns at the negedge where the response is due.
  task automatic issue(input logic [1:0] en, input int r0, input int h0,
                       input int r1, input int h1);
    @(negedge clk);
    rd_en = en; rd_row = {3'(r1), 3'(r0)}; rd_h = {2'(h1), 2'(h0)};
    @(negedge clk);
    rd_en = '0;
    chk("R3 no early valid", 32'(rd_valid), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(rd_valid), 32'd0);
    chk("R1 data in reset", 32'(rd_data), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(rd_valid), 32'd0);
    chk("R1 data after reset", 32'(rd_data), 32'd0);

    for (int v = 0; v < V; v++) write_row(v, row_pat(v), 1'b1);

    // Table walk, alternating ports (R2, R4, R9).
    for (int i = 0; i < 8; i++) begin
      int port;
      port = i % 2;
      issue(2'(1 << port), int'(VEC[i][12:10]), int'(VEC[i][9:8]),
            int'(VEC[i][12:10]), int'(VEC[i][9:8]));
      chk("R3 valid on time", 32'(rd_valid[port]), 32'd1);
      chk("R2/R4/R9 table entry", 32'(rd_data[port*B +: B]),
          32'(VEC[i][7:0]));
    end

    // R7: idle cycle, lane holds.
    begin
      logic [B-1:0] held;
      held = rd_data[B +: B];
      @(negedge clk);
      chk("R7 valid low when idle", 32'(rd_valid), 32'd0);
      chk("R7 data held", 32'(rd_data[B +: B]), 32'(held));
    end

    // R6: both ports, different then identical coordinates.
    issue(2'b11, 1, 0, 7, 1);
    chk("R6 port0 own entry", 32'(rd_data[0 +: B]), 32'h11);
    chk("R6 port1 own entry", 32'(rd_data[B +: B]), 32'h72);
    issue(2'b11, 6, 2, 6, 2);
    chk("R6 same request port0", 32'(rd_data[0 +: B]), 32'h63);
    chk("R6 same request port1", 32'(rd_data[B +: B]), 32'h63);

    // R9: straddling entry on row 5.
    issue(2'b01, 5, 1, 0, 0);
    chk("R9 entry across column split", 32'(rd_data[0 +: B]), 32'h52);

    // R8: write with wr_en low has no effect.
    write_row(3, 24'hAABBCC, 1'b0);
    issue(2'b10, 0, 0, 3, 2);
    chk("R8 disabled write ignored", 32'(rd_data[B +: B]), 32'h33);

    // R5: read-first on the same row in the same cycle.
    @(negedge clk);
    wr_en = 1'b1; wr_row = 3'd2; wr_data = 24'hC3B2A1;
    rd_en = 2'b01; rd_row = {3'd0, 3'd2}; rd_h = {2'd0, 2'd0};
    @(negedge clk);
    wr_en = 1'b0; rd_en = '0;
    @(negedge clk);
    chk("R5 old data on collision", 32'(rd_data[0 +: B]), 32'h21);
    issue(2'b01, 2, 2, 0, 0);
    chk("R2/R5 new row after write", 32'(rd_data[0 +: B]), 32'hC3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
    end
  end
endmodule